// File: doc/BRIEF.md
# Split Row/Column Command Scheduler

This block turns an in-order stream of memory transactions into command packets for a channel with two separate command lanes. One lane carries row packets (device, bank, row) and the other carries column packets (device, bank, column, direction). Because the lanes are independent, the row packet of a later transaction can leave in the same cycle as the column packet of an earlier one. The row lane may run a bounded number of transactions ahead of the column lane.

Every transaction moves 32 bytes. At the default beat width of 8 bytes that is a burst of four data cycles. Read and write data start the same fixed number of cycles after their column packet. A read followed by a write therefore needs no idle data cycle, and neither do two reads to different devices. A write followed by a read gets a short, parameterised idle gap. The block also publishes a per-cycle data-slot schedule: whether the data bus is busy, in which direction, and for which device.

Top module: `split_bus_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rowValid`, `colValid` and `dataValid` are low and `reqReady` is high.
- R2: A request accepted in a cycle (`reqValid` and `reqReady` both high) produces a row packet in the next cycle, carrying the request's device, bank and row.
- R3: The column packet of a transaction appears no earlier than `T_RCD` cycles after its row packet. It appears exactly `T_RCD` cycles later when the column lane has no spacing constraint pending.
- R4: Column packets leave in acceptance order and carry the device, bank, column and direction (`colWrite` = 1 for a write) of their transaction.
- R5: The number of transactions with a row packet but no column packet yet never exceeds `MAX_AHEAD`. `reqReady` is low exactly when that number equals `MAX_AHEAD`.
- R6: A column packet in cycle c makes `dataValid` high from cycle c+`COL_LAT` to cycle c+`COL_LAT`+B-1, where B = `XFER_BYTES`/`BEAT_BYTES`. During those cycles `dataWrite` and `dataDev` equal the packet's direction and device.
- R7: Two consecutive column packets are at least B cycles apart. A column packet whose predecessor was a read, whatever the device, issues exactly B cycles after that predecessor if its row delay has already elapsed.
- R8: A read column packet that follows a write column packet is at least B+`WR_RD_GAP` cycles after it, and exactly that when nothing else holds it back.
- R9: A row packet and a column packet of different transactions can be valid in the same cycle.
- R10: No two transactions ever hold the data bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Request is taken this cycle if valid |
| reqDev | input | DEV_W | Target device |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| rowValid | output | 1 | Row lane packet valid |
| rowDev | output | DEV_W | Row packet device |
| rowBank | output | BANK_W | Row packet bank |
| rowAddr | output | ROW_W | Row packet row address |
| colValid | output | 1 | Column lane packet valid |
| colDev | output | DEV_W | Column packet device |
| colBank | output | BANK_W | Column packet bank |
| colAddr | output | COL_W | Column packet column address |
| colWrite | output | 1 | Column packet direction, 1 = write |
| dataValid | output | 1 | Data bus slot occupied this cycle |
| dataWrite | output | 1 | Direction of the occupied slot |
| dataDev | output | DEV_W | Device owning the occupied slot |

## Verification
The bench builds the block with `T_RCD` = 3, `WR_RD_GAP` = 2, `MAX_AHEAD` = 3 and `COL_LAT` = 2, with the default 32-byte transfer over 8-byte beats. A row delay shorter than the four-cycle burst, together with a lookahead of three, lets the row lane fill up behind the column lane, so concurrent row and column issue and a blocked `reqReady` both occur. The two-cycle write-to-read gap can be told apart from ordinary burst spacing. Dense traffic exercises back-to-back spacing, and sparse traffic exposes the exact row-to-column delay on an idle lane.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Widest slot index carried between control and datapath (lookahead up to 16)
  localparam int unsigned SLOT_IDX_W = 4;

  typedef struct packed {
    logic                  push;
    logic [SLOT_IDX_W-1:0] pushIdx;
    logic                  pop;
    logic [SLOT_IDX_W-1:0] popIdx;
  } sbs_strobe_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned MAX_AHEAD = 2,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned BURST     = 4,
  parameter int unsigned WR_RD_GAP = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        headWrite,
  output logic        reqReady,
  output sbs_strobe_t strobes
);
  localparam int unsigned IDX_W  = (MAX_AHEAD > 1) ? $clog2(MAX_AHEAD) : 1;
  localparam int unsigned CNT_W  = $clog2(MAX_AHEAD + 1);
  localparam int unsigned RCD_W  = $clog2(T_RCD + 1);
  localparam int unsigned SP_MAX = BURST + WR_RD_GAP;
  localparam int unsigned SP_W   = $clog2(SP_MAX + 1);

  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] wrPtr, rdPtr;
  logic [RCD_W-1:0] rcdLeft [MAX_AHEAD];
  logic [SP_W-1:0]  spaceCnt, needSpace;
  logic             lastWr, accept, headReady, colFire;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(MAX_AHEAD - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    reqReady  = count < CNT_W'(MAX_AHEAD);
    accept    = reqValid && reqReady;
    headReady = (count != '0) && (rcdLeft[rdPtr] == '0);
    // write data then read data needs extra idle beats on the shared data bus
    needSpace = (lastWr && !headWrite) ? SP_W'(SP_MAX) : SP_W'(BURST);
    colFire   = headReady && (spaceCnt >= needSpace);
    strobes.push    = accept;
    strobes.pushIdx = SLOT_IDX_W'(wrPtr);
    strobes.pop     = colFire;
    strobes.popIdx  = SLOT_IDX_W'(rdPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      spaceCnt <= SP_W'(SP_MAX);
      lastWr   <= 1'b0;
      for (int i = 0; i < MAX_AHEAD; i++) rcdLeft[i] <= '0;
    end else begin
      count <= count + CNT_W'(accept) - CNT_W'(colFire);
      if (accept)  wrPtr <= nextIdx(wrPtr);
      if (colFire) begin
        rdPtr    <= nextIdx(rdPtr);
        lastWr   <= headWrite;
        spaceCnt <= SP_W'(1);
      end else if (spaceCnt != SP_W'(SP_MAX)) begin
        spaceCnt <= spaceCnt + 1'b1;
      end
      for (int i = 0; i < MAX_AHEAD; i++) begin
        if (accept && (wrPtr == IDX_W'(i))) rcdLeft[i] <= RCD_W'(T_RCD - 1);
        else if (rcdLeft[i] != '0)           rcdLeft[i] <= rcdLeft[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned ROW_W     = 9,
  parameter int unsigned COL_W     = 6,
  parameter int unsigned MAX_AHEAD = 2,
  parameter int unsigned COL_LAT   = 2,
  parameter int unsigned BURST     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbs_strobe_t       strobes,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  output logic              headWrite,
  output logic              rowValid,
  output logic [DEV_W-1:0]  rowDev,
  output logic [BANK_W-1:0] rowBank,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              colValid,
  output logic [DEV_W-1:0]  colDev,
  output logic [BANK_W-1:0] colBank,
  output logic [COL_W-1:0]  colAddr,
  output logic              colWrite,
  output logic              dataValid,
  output logic              dataWrite,
  output logic [DEV_W-1:0]  dataDev
);
  localparam int unsigned IDX_W = (MAX_AHEAD > 1) ? $clog2(MAX_AHEAD) : 1;
  localparam int unsigned BL_W  = $clog2(BURST + 1);

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic              wr;
  } slot_t;

  slot_t            slotMem [MAX_AHEAD];
  logic [IDX_W-1:0] wIdx, rIdx;
  logic             dlyV   [COL_LAT];
  logic             dlyW   [COL_LAT];
  logic [DEV_W-1:0] dlyDev [COL_LAT];
  logic [BL_W-1:0]  burstLeft;
  logic             heldW;
  logic [DEV_W-1:0] heldDev;

  assign wIdx      = strobes.pushIdx[IDX_W-1:0];
  assign rIdx      = strobes.popIdx[IDX_W-1:0];
  assign headWrite = slotMem[rIdx].wr;

  always_ff @(posedge clk) begin
    if (strobes.push) slotMem[wIdx] <= '{dev: reqDev, bank: reqBank, col: reqCol, wr: reqWrite};
  end

  // Packet registers for both command lanes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowValid <= 1'b0; rowDev <= '0; rowBank <= '0; rowAddr <= '0;
      colValid <= 1'b0; colDev <= '0; colBank <= '0; colAddr <= '0; colWrite <= 1'b0;
    end else begin
      rowValid <= strobes.push;
      if (strobes.push) begin
        rowDev <= reqDev; rowBank <= reqBank; rowAddr <= reqRow;
      end
      colValid <= strobes.pop;
      if (strobes.pop) begin
        colDev   <= slotMem[rIdx].dev;
        colBank  <= slotMem[rIdx].bank;
        colAddr  <= slotMem[rIdx].col;
        colWrite <= slotMem[rIdx].wr;
      end
    end
  end

  // Data-slot schedule: fixed offset after the column packet, same for both directions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < COL_LAT; s++) begin
        dlyV[s] <= 1'b0; dlyW[s] <= 1'b0; dlyDev[s] <= '0;
      end
      burstLeft <= '0;
      heldW     <= 1'b0;
      heldDev   <= '0;
    end else begin
      dlyV[0] <= colValid; dlyW[0] <= colWrite; dlyDev[0] <= colDev;
      for (int s = 1; s < COL_LAT; s++) begin
        dlyV[s] <= dlyV[s-1]; dlyW[s] <= dlyW[s-1]; dlyDev[s] <= dlyDev[s-1];
      end
      if (dlyV[COL_LAT-1]) begin
        burstLeft <= BL_W'(BURST - 1);
        heldW     <= dlyW[COL_LAT-1];
        heldDev   <= dlyDev[COL_LAT-1];
      end else if (burstLeft != '0) begin
        burstLeft <= burstLeft - 1'b1;
      end
    end
  end

  always_comb begin
    dataValid = dlyV[COL_LAT-1] || (burstLeft != '0);
    dataWrite = dlyV[COL_LAT-1] ? dlyW[COL_LAT-1]   : heldW;
    dataDev   = dlyV[COL_LAT-1] ? dlyDev[COL_LAT-1] : heldDev;
  end
endmodule

// File: rtl/split_bus_sched.sv
module split_bus_sched
  import sbs_pkg::*;
#(
  parameter int unsigned DEV_W      = 2,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned ROW_W      = 9,
  parameter int unsigned COL_W      = 6,
  parameter int unsigned XFER_BYTES = 32,
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned T_RCD      = 3,
  parameter int unsigned WR_RD_GAP  = 1,
  parameter int unsigned COL_LAT    = 2,
  parameter int unsigned MAX_AHEAD  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  output logic              rowValid,
  output logic [DEV_W-1:0]  rowDev,
  output logic [BANK_W-1:0] rowBank,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              colValid,
  output logic [DEV_W-1:0]  colDev,
  output logic [BANK_W-1:0] colBank,
  output logic [COL_W-1:0]  colAddr,
  output logic              colWrite,
  output logic              dataValid,
  output logic              dataWrite,
  output logic [DEV_W-1:0]  dataDev
);
  localparam int unsigned BURST = XFER_BYTES / BEAT_BYTES;

  sbs_strobe_t strobes;
  logic        headWrite;

  sbs_ctrl #(
    .MAX_AHEAD(MAX_AHEAD), .T_RCD(T_RCD), .BURST(BURST), .WR_RD_GAP(WR_RD_GAP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .headWrite(headWrite),
    .reqReady(reqReady), .strobes(strobes)
  );

  sbs_datapath #(
    .DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .MAX_AHEAD(MAX_AHEAD), .COL_LAT(COL_LAT), .BURST(BURST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqDev(reqDev), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite),
    .headWrite(headWrite),
    .rowValid(rowValid), .rowDev(rowDev), .rowBank(rowBank), .rowAddr(rowAddr),
    .colValid(colValid), .colDev(colDev), .colBank(colBank), .colAddr(colAddr), .colWrite(colWrite),
    .dataValid(dataValid), .dataWrite(dataWrite), .dataDev(dataDev)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned MAX_AHEAD = 2,
  parameter int unsigned BURST     = 4,
  parameter int unsigned WR_RD_GAP = 1
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rowValid,
  input logic colValid,
  input logic colWrite
);
  localparam int unsigned CNT_W  = $clog2(MAX_AHEAD + 1) + 1;
  localparam int unsigned SP_MAX = BURST + WR_RD_GAP;
  localparam int unsigned SP_W   = $clog2(SP_MAX + 1);

  logic [CNT_W-1:0] outPrev, outNow;
  logic [SP_W-1:0]  sinceCol, minGap;
  logic             prevWr;

  always_comb begin
    outNow = outPrev + CNT_W'(rowValid) - CNT_W'(colValid);
    minGap = (prevWr && !colWrite) ? SP_W'(SP_MAX) : SP_W'(BURST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPrev  <= '0;
      sinceCol <= SP_W'(SP_MAX);
      prevWr   <= 1'b0;
    end else begin
      outPrev <= outNow;
      if (colValid) begin
        sinceCol <= SP_W'(1);
        prevWr   <= colWrite;
      end else if (sinceCol != SP_W'(SP_MAX)) begin
        sinceCol <= sinceCol + 1'b1;
      end
    end
  end

  p_ahead_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    outNow <= CNT_W'(MAX_AHEAD));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outNow == CNT_W'(MAX_AHEAD)) |-> !reqReady);

  p_col_after_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> (outPrev != '0));

  // covers R8 as well: the minimum rises by the write-to-read gap
  p_col_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> (sinceCol >= minGap));
endmodule

bind split_bus_sched sbs_checker #(
  .MAX_AHEAD(MAX_AHEAD), .BURST(XFER_BYTES / BEAT_BYTES), .WR_RD_GAP(WR_RD_GAP)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady),
  .rowValid(rowValid), .colValid(colValid), .colWrite(colWrite)
);

// File: tb/split_bus_sched_tb.sv
module split_bus_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEV_W = 2, BANK_W = 4, ROW_W = 9, COL_W = 6;
  localparam int T_RCD = 3, GAP = 2, COL_LAT = 2, MAX_AHEAD = 3;
  localparam int BURST = 32 / 8;
  localparam int NMAX = 8192;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [DEV_W-1:0] reqDev = '0;
  logic [BANK_W-1:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic reqReady, rowValid, colValid, colWrite, dataValid, dataWrite;
  logic [DEV_W-1:0] rowDev, colDev, dataDev;
  logic [BANK_W-1:0] rowBank, colBank;
  logic [ROW_W-1:0] rowAddr;
  logic [COL_W-1:0] colAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_bus_sched #(
    .DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .XFER_BYTES(32), .BEAT_BYTES(8), .T_RCD(T_RCD), .WR_RD_GAP(GAP),
    .COL_LAT(COL_LAT), .MAX_AHEAD(MAX_AHEAD)
  ) dut_i (.*);

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;
  int mDev[NMAX], mBank[NMAX], mRow[NMAX], mCol[NMAX], mWr[NMAX], rowT[NMAX], colT[NMAX];
  int nAcc = 0, nCol = 0, lastColT = -1000, lastWr = 0, lastDev = 0;
  bit rowPend = 0;
  int concur = 0, exactRcd = 0, tightRdWr = 0, tightRdRdDiff = 0, wrRdGap = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one cycle: sample at the falling edge, then drive for the next rising edge
  task automatic doCycle(input bit want, input int forceWr, input int forceDev, output bit acc);
    bit expCol, expReady;
    int h, need, earliest, hits, hitIdx;
    @(negedge clk);
    cyc++;
    // R2: row packet one cycle after acceptance
    chk(rowValid == rowPend, "R2", "rowValid", rowValid, rowPend);
    if (rowPend && rowValid) begin
      chk(int'(rowDev) == mDev[nAcc-1], "R2", "rowDev", rowDev, mDev[nAcc-1]);
      chk(int'(rowBank) == mBank[nAcc-1], "R2", "rowBank", rowBank, mBank[nAcc-1]);
      chk(int'(rowAddr) == mRow[nAcc-1], "R2", "rowAddr", rowAddr, mRow[nAcc-1]);
    end
    rowPend = 0;
    // R3/R7/R8: column issue time
    expCol = 0;
    h = nCol;
    if (nCol < nAcc) begin
      need = BURST + ((lastWr == 1 && mWr[h] == 0) ? GAP : 0);
      earliest = maxi(rowT[h] + T_RCD, lastColT + need);
      expCol = (cyc == earliest);
    end
    chk(colValid == expCol, "R3/R7/R8", "colValid", colValid, expCol);
    if (expCol && colValid) begin
      chk(int'(colDev) == mDev[h], "R4", "colDev", colDev, mDev[h]);
      chk(int'(colBank) == mBank[h], "R4", "colBank", colBank, mBank[h]);
      chk(int'(colAddr) == mCol[h], "R4", "colAddr", colAddr, mCol[h]);
      chk(int'(colWrite) == mWr[h], "R4", "colWrite", colWrite, mWr[h]);
    end
    if (expCol) begin
      if (cyc == rowT[h] + T_RCD && cyc - lastColT > BURST + GAP) exactRcd++;
      if (lastWr == 0 && mWr[h] == 1 && cyc - lastColT == BURST) tightRdWr++;
      if (lastWr == 0 && mWr[h] == 0 && mDev[h] != lastDev && cyc - lastColT == BURST) tightRdRdDiff++;
      if (lastWr == 1 && mWr[h] == 0 && cyc - lastColT == BURST + GAP) wrRdGap++;
      colT[h] = cyc; lastColT = cyc; lastWr = mWr[h]; lastDev = mDev[h];
      nCol++;
    end
    if (rowValid && colValid) concur++;
    // R6/R10: data slot schedule
    hits = 0; hitIdx = 0;
    for (int k = maxi(0, nCol - 3); k < nCol; k++) begin
      if (cyc >= colT[k] + COL_LAT && cyc < colT[k] + COL_LAT + BURST) begin
        hits++; hitIdx = k;
      end
    end
    chk(hits <= 1, "R10", "overlapping data owners", hits, 1);
    chk(dataValid == (hits > 0), "R6", "dataValid", dataValid, hits > 0);
    if (hits > 0 && dataValid) begin
      chk(int'(dataWrite) == mWr[hitIdx], "R6", "dataWrite", dataWrite, mWr[hitIdx]);
      chk(int'(dataDev) == mDev[hitIdx], "R6", "dataDev", dataDev, mDev[hitIdx]);
    end
    // R5: lookahead limit seen through reqReady
    expReady = (nAcc - nCol) < MAX_AHEAD;
    chk(reqReady == expReady, "R5", "reqReady", reqReady, expReady);
    // drive
    reqValid = want;
    reqWrite = (forceWr < 0) ? 1'($urandom_range(0, 1)) : 1'(forceWr);
    reqDev   = (forceDev < 0) ? DEV_W'($urandom) : DEV_W'(forceDev);
    reqBank  = BANK_W'($urandom);
    reqRow   = ROW_W'($urandom);
    reqCol   = COL_W'($urandom);
    acc = want && expReady;
    if (acc && nAcc < NMAX) begin
      mDev[nAcc] = reqDev; mBank[nAcc] = reqBank; mRow[nAcc] = reqRow;
      mCol[nAcc] = reqCol; mWr[nAcc] = reqWrite; rowT[nAcc] = cyc + 1;
      nAcc++;
      rowPend = 1;
    end
  endtask

  initial begin
    bit acc;
    int idx;
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    // R1: reset state, still in reset
    chk(!rowValid && !colValid && !dataValid, "R1", "valids in reset", rowValid | colValid | dataValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!rowValid && !colValid && !dataValid, "R1", "valids after release", rowValid | colValid | dataValid, 0);
    chk(reqReady == 1'b1, "R1", "reqReady after release", reqReady, 1);
    // directed: W R R W W R R with rotating devices (R7, R8)
    idx = 0;
    while (idx < 28) begin
      doCycle(1, (idx % 7 == 0 || idx % 7 == 3 || idx % 7 == 4) ? 1 : 0, idx % 4, acc);
      if (acc) idx++;
    end
    repeat (20) doCycle(0, -1, -1, acc);
    // dense random traffic
    repeat (3000) doCycle($urandom_range(0, 99) < 75, -1, -1, acc);
    // sparse traffic exposes idle-lane row-to-column delay (R3)
    repeat (1500) doCycle($urandom_range(0, 99) < 8, -1, -1, acc);
    repeat (20) doCycle(0, -1, -1, acc);
    chk(nCol == nAcc, "R4", "all accepted transactions issued", nCol, nAcc);
    chk(concur > 0, "R9", "cycles with row and column together", concur, 1);
    chk(exactRcd > 0, "R3", "idle-lane column at exact row delay", exactRcd, 1);
    chk(tightRdWr > 0, "R7", "read-to-write without idle slot", tightRdWr, 1);
    chk(tightRdRdDiff > 0, "R7", "read-to-read other device without idle slot", tightRdRdDiff, 1);
    chk(wrRdGap > 0, "R8", "write-to-read with gap", wrRdGap, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule